// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

This block drives one 16-bit DRAM region from a simple request port. A request carries a word address, a read/write flag, two byte enables and write data, and is taken on a valid/ready handshake. On the memory side the block drives a row strobe, an upper-lane and a lower-lane column strobe, write enable, output enable, and one address bus that carries the row and the column in turn. Read data is captured from the memory data bus and returned on a one-cycle response pulse.

Two access styles are selectable. In plain mode each access opens its row, runs one column cycle and closes the row again. In page mode the row is left open after a column cycle. A following access to the same row then needs only a new column cycle. An access to another row closes the open row with a precharge state and then opens the new one. A configuration code picks how many low word-address bits form the column (8 to 11). The bits above the column form the row. They are used both for the row comparison and for the row phase on the address bus. An open row that sees no request for a programmable number of cycles is closed.

Top module: `dram_page_ctrl`

## Requirements
- R1: With `cfg_burst_en` low, every access is row strobe fall, column cycle, then row strobe high in the state that directly follows the column-strobe state.
- R2: With `cfg_burst_en` high, accesses to the row that is already open give no row strobe edge between them; only column cycles are issued.
- R3: A column cycle is two states: first a state with the column address on `dram_addr`, the row strobe low and both column strobes high, then exactly one state with the selected column strobes low and the same address held.
- R4: `cfg_shift` codes 0, 1, 2, 3 select a column width S of 8, 9, 10, 11 bits, and codes 4 to 7 select 11. The column on `dram_addr` is `req_waddr[S-1:0]` zero-extended. The row phase puts `req_waddr >> S` (low 11 bits) on the bus. The page comparison uses all bits of `req_waddr >> S`.
- R5: `req_be[1]` selects the upper column strobe (data bits 15..8) and `req_be[0]` selects the lower column strobe (bits 7..0).
- R6: For a write, `dram_we_n` is low and `dram_dq_oe` high across both column states, with the write data on `dram_dq_o`. For a read, `dram_oe_n` is low across both column states. `dram_dq_i` is sampled at the end of the column-strobe state, and `rsp_valid` pulses in the next state with that value on `rsp_rdata`.
- R7: In page mode, an access to a different row raises the row strobe for at least one state of precharge before the new row address is strobed.
- R8: An open row with no request is closed after exactly `cfg_idle_limit`+1 idle states following its column-strobe state.
- R9: A column strobe is low only while the row strobe is low, and write enable and output enable are never low together.
- R10: After reset all strobes are high, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst_en | input | 1 | 1 selects page mode, 0 plain mode |
| cfg_shift | input | 3 | Column-width code (8 + code bits, clamped to 11) |
| cfg_idle_limit | input | IDLE_W | Idle states before an open row is closed, minus one |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request may be taken this cycle |
| req_waddr | input | WADDR_W | Word address |
| req_write | input | 1 | 1 write, 0 read |
| req_be | input | 2 | Byte-lane enables, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-lane column strobe, active low |
| dram_lcas_n | output | 1 | Lower-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | PIN_W | Multiplexed row/column address |
| dram_dq_o | output | 16 | Write data to memory |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_i | input | 16 | Read data from memory |

## Verification
The assertions watch the pin protocol every cycle. They check that column strobes appear only inside an open row, that the strobe state is exactly one cycle long with its address held from the setup state, that plain mode closes the row right after the column strobe, and that write and output enable never overlap. The row and column values for each shift code, the open-row reuse across several accesses, the precharge on a row miss, the exact idle-close count and the returned read data can only be shown by the bench's scenarios. There a behavioural memory model decodes the pins and a scoreboard compares every column cycle and every response against the issued requests.

// File: rtl/dram_pkg.sv
package dram_pkg;

   localparam int DQ_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ROW  = 3'd1,
      ST_COLA = 3'd2,
      ST_COLB = 3'd3,
      ST_OPEN = 3'd4,
      ST_PRE  = 3'd5
   } seq_state_t;

   // Clamp a column-width code to the number of implemented variants.
   function automatic logic [2:0] shift_clamp(input logic [2:0] code, input int n_var);
      if (int'(code) >= n_var) return 3'(n_var - 1);
      return code;
   endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
   parameter int WORD_W     = 23,
   parameter int BASE_SHIFT = 8,
   parameter int N_SHIFTS   = 4,
   parameter int PIN_W      = 11
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [WORD_W-1:0] word_q,
   input  logic [2:0]        shift_code,
   output logic [WORD_W-1:0] tag_in,
   output logic [PIN_W-1:0]  row_pins,
   output logic [PIN_W-1:0]  col_pins
);
   import dram_pkg::*;

   logic [WORD_W-1:0] tag_v [8];
   logic [PIN_W-1:0]  row_v [8];
   logic [PIN_W-1:0]  col_v [8];
   logic [2:0]        sel;

   for (genvar g = 0; g < 8; g++) begin : g_var
      if (g < N_SHIFTS) begin : g_used
         localparam int S = BASE_SHIFT + g;
         localparam logic [WORD_W-1:0] MASK = (WORD_W'(1) << S) - WORD_W'(1);
         assign tag_v[g] = word_in >> S;
         assign row_v[g] = PIN_W'(word_q >> S);
         assign col_v[g] = PIN_W'(word_q & MASK);
      end else begin : g_unused
         assign tag_v[g] = '0;
         assign row_v[g] = '0;
         assign col_v[g] = '0;
      end
   end

   assign sel      = shift_clamp(shift_code, N_SHIFTS);
   assign tag_in   = tag_v[sel];
   assign row_pins = row_v[sel];
   assign col_pins = col_v[sel];

endmodule

// File: rtl/dram_row_track.sv
module dram_row_track #(
   parameter int WORD_W = 23,
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_tag,
   input  logic [WORD_W-1:0] tag_in,
   input  logic              idle_tick,
   input  logic              idle_clr,
   input  logic [IDLE_W-1:0] idle_limit,
   output logic              row_hit,
   output logic              idle_expire
);
   logic [WORD_W-1:0] tag_q;
   logic [IDLE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= '0;
      else if (load_tag) tag_q <= tag_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (idle_clr) cnt_q <= '0;
      else if (idle_tick) cnt_q <= cnt_q + IDLE_W'(1);
   end

   assign row_hit     = (tag_q == tag_in);
   assign idle_expire = idle_tick && (cnt_q >= idle_limit);

   // R8: every open period starts counting from zero
   p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idle_clr |=> (cnt_q == '0));

   // R2: a freshly stored tag compares equal to the same incoming row
   p_tag_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_tag && !idle_clr) |=> (tag_q == $past(tag_in)));

endmodule

// File: rtl/dram_seq.sv
module dram_seq (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                row_hit,
   input  logic                burst_en,
   input  logic                idle_expire,
   output dram_pkg::seq_state_t st,
   output logic                req_ready,
   output logic                accept,
   output logic                load_tag,
   output logic                idle_tick,
   output logic                idle_clr
);
   import dram_pkg::*;

   seq_state_t st_q, st_d;
   logic       pend_q, pend_set;

   always_comb begin
      st_d      = st_q;
      accept    = 1'b0;
      load_tag  = 1'b0;
      idle_tick = 1'b0;
      idle_clr  = 1'b0;
      pend_set  = 1'b0;
      case (st_q)
         ST_IDLE: if (req_valid) begin
            accept   = 1'b1;
            load_tag = 1'b1;
            st_d     = ST_ROW;
         end
         ST_ROW:  st_d = ST_COLA;
         ST_COLA: st_d = ST_COLB;
         ST_COLB: begin
            if (burst_en) begin
               st_d     = ST_OPEN;
               idle_clr = 1'b1;
            end else begin
               st_d = ST_PRE;
            end
         end
         ST_OPEN: begin
            if (req_valid) begin
               accept = 1'b1;
               if (row_hit) begin
                  st_d = ST_COLA;
               end else begin
                  load_tag = 1'b1;
                  pend_set = 1'b1;
                  st_d     = ST_PRE;
               end
            end else begin
               idle_tick = 1'b1;
               if (idle_expire) st_d = ST_PRE;
            end
         end
         ST_PRE:  st_d = pend_q ? ST_ROW : ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (pend_set) pend_q <= 1'b1;
         else if (st_q == ST_PRE) pend_q <= 1'b0;
      end
   end

   assign st        = st_q;
   assign req_ready = (st_q == ST_IDLE) || (st_q == ST_OPEN);

   // R7: a queued miss reopens a row straight after its precharge state
   p_miss_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_OPEN && accept && !row_hit) |=> (st_q == ST_PRE) ##1 (st_q == ST_ROW));

   // R3: the column setup state always leads into the strobe state
   p_col_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_COLA) |=> (st_q == ST_COLB));

endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive #(
   parameter int PIN_W = 11
) (
   input  dram_pkg::seq_state_t st,
   input  logic                 write_q,
   input  logic [1:0]           be_q,
   input  logic [PIN_W-1:0]     row_pins,
   input  logic [PIN_W-1:0]     col_pins,
   output logic                 ras_n,
   output logic                 ucas_n,
   output logic                 lcas_n,
   output logic                 we_n,
   output logic                 oe_n,
   output logic                 dq_oe,
   output logic [PIN_W-1:0]     addr
);
   import dram_pkg::*;

   logic row_open, in_col, strobe;

   always_comb begin
      row_open = (st == ST_ROW) || (st == ST_COLA) || (st == ST_COLB) || (st == ST_OPEN);
      in_col   = (st == ST_COLA) || (st == ST_COLB);
      strobe   = (st == ST_COLB);
      ras_n    = !row_open;
      ucas_n   = !(strobe && be_q[1]);
      lcas_n   = !(strobe && be_q[0]);
      we_n     = !(in_col && write_q);
      oe_n     = !(in_col && !write_q);
      dq_oe    = in_col && write_q;
      addr     = (st == ST_ROW) ? row_pins : col_pins;
   end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
   parameter int WADDR_W    = 23,
   parameter int BASE_SHIFT = 8,
   parameter int N_SHIFTS   = 4,
   parameter int IDLE_W     = 8,
   localparam int PIN_W     = BASE_SHIFT + N_SHIFTS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_burst_en,
   input  logic [2:0]          cfg_shift,
   input  logic [IDLE_W-1:0]   cfg_idle_limit,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [WADDR_W-1:0]  req_waddr,
   input  logic                req_write,
   input  logic [1:0]          req_be,
   input  logic [15:0]         req_wdata,
   output logic                rsp_valid,
   output logic [15:0]         rsp_rdata,
   output logic                dram_ras_n,
   output logic                dram_ucas_n,
   output logic                dram_lcas_n,
   output logic                dram_we_n,
   output logic                dram_oe_n,
   output logic [PIN_W-1:0]    dram_addr,
   output logic [15:0]         dram_dq_o,
   output logic                dram_dq_oe,
   input  logic [15:0]         dram_dq_i
);
   import dram_pkg::*;

   if (BASE_SHIFT < 1 || N_SHIFTS < 1 || N_SHIFTS > 8 || WADDR_W < 2 * PIN_W ||
       IDLE_W < 1) begin : g_bad_cfg
      $error("dram_page_ctrl: unsupported parameter combination");
   end

   seq_state_t          st;
   logic                accept, load_tag, idle_tick, idle_clr;
   logic                row_hit, idle_expire;
   logic [WADDR_W-1:0]  waddr_q, tag_in;
   logic                write_q;
   logic [1:0]          be_q;
   logic [DQ_W-1:0]     wdata_q, rdata_q;
   logic                rsp_q;
   logic [PIN_W-1:0]    row_pins, col_pins;

   dram_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .row_hit    (row_hit),
      .burst_en   (cfg_burst_en),
      .idle_expire(idle_expire),
      .st         (st),
      .req_ready  (req_ready),
      .accept     (accept),
      .load_tag   (load_tag),
      .idle_tick  (idle_tick),
      .idle_clr   (idle_clr)
   );

   dram_addr_split #(
      .WORD_W(WADDR_W), .BASE_SHIFT(BASE_SHIFT), .N_SHIFTS(N_SHIFTS), .PIN_W(PIN_W)
   ) u_split (
      .word_in   (req_waddr),
      .word_q    (waddr_q),
      .shift_code(cfg_shift),
      .tag_in    (tag_in),
      .row_pins  (row_pins),
      .col_pins  (col_pins)
   );

   dram_row_track #(.WORD_W(WADDR_W), .IDLE_W(IDLE_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_tag   (load_tag),
      .tag_in     (tag_in),
      .idle_tick  (idle_tick),
      .idle_clr   (idle_clr),
      .idle_limit (cfg_idle_limit),
      .row_hit    (row_hit),
      .idle_expire(idle_expire)
   );

   dram_pin_drive #(.PIN_W(PIN_W)) u_pins (
      .st      (st),
      .write_q (write_q),
      .be_q    (be_q),
      .row_pins(row_pins),
      .col_pins(col_pins),
      .ras_n   (dram_ras_n),
      .ucas_n  (dram_ucas_n),
      .lcas_n  (dram_lcas_n),
      .we_n    (dram_we_n),
      .oe_n    (dram_oe_n),
      .dq_oe   (dram_dq_oe),
      .addr    (dram_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waddr_q <= '0;
         write_q <= 1'b0;
         be_q    <= 2'b00;
         wdata_q <= '0;
      end else if (accept) begin
         waddr_q <= req_waddr;
         write_q <= req_write;
         be_q    <= req_be;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         rsp_q <= (st == ST_COLB) && !write_q;
         if ((st == ST_COLB) && !write_q) rdata_q <= dram_dq_i;
      end
   end

   assign rsp_valid = rsp_q;
   assign rsp_rdata = rdata_q;
   assign dram_dq_o = wdata_q;

   // R9: column strobes only inside an open row
   p_cas_in_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ucas_n || !dram_lcas_n) |-> !dram_ras_n);

   // R9: read and write enables are exclusive
   p_we_oe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dram_we_n && !dram_oe_n));

   // R3: strobe state lasts one state
   p_cas_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ucas_n || !dram_lcas_n) |=> (dram_ucas_n && dram_lcas_n));

   // R3: column address held from the setup state, row already open
   p_col_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ucas_n || !dram_lcas_n) |-> ($stable(dram_addr) && !$past(dram_ras_n)
                                          && $past(dram_ucas_n) && $past(dram_lcas_n)));

   // R1: plain mode closes the row right after the strobe state
   p_plain_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_burst_en && (!dram_ucas_n || !dram_lcas_n)) |=> dram_ras_n);

   // R7: a row opens only with column strobes quiet
   p_row_open_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (dram_ucas_n && dram_lcas_n && dram_we_n && dram_oe_n));

   // R6: read response follows the strobe state of a read
   p_rsp_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!dram_oe_n && (!dram_ucas_n || !dram_lcas_n)));

   // R2: a taken request never coincides with a strobe state
   p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (dram_ucas_n && dram_lcas_n));

endmodule

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;

   localparam int WADDR_W = 23;
   localparam int IDLE_W  = 8;
   localparam int PIN_W   = 11;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_burst_en = 1'b0;
   logic [2:0]         cfg_shift = 3'd2;
   logic [IDLE_W-1:0]  cfg_idle_limit = 8'd4;
   logic               req_valid = 1'b0;
   logic               req_ready;
   logic [WADDR_W-1:0] req_waddr = '0;
   logic               req_write = 1'b0;
   logic [1:0]         req_be = 2'b11;
   logic [15:0]        req_wdata = '0;
   logic               rsp_valid;
   logic [15:0]        rsp_rdata;
   logic               dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n;
   logic [PIN_W-1:0]   dram_addr;
   logic [15:0]        dram_dq_o;
   logic               dram_dq_oe;
   logic [15:0]        dram_dq_i = '0;

   always #4 clk = ~clk;

   dram_page_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_burst_en(cfg_burst_en), .cfg_shift(cfg_shift),
      .cfg_idle_limit(cfg_idle_limit), .req_valid(req_valid), .req_ready(req_ready),
      .req_waddr(req_waddr), .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
      .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_o(dram_dq_o),
      .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
   );

   typedef struct packed {
      logic [WADDR_W-1:0] w;
      logic               wr;
      logic [1:0]         be;
      logic [15:0]        d;
   } item_t;

   item_t       colq[$];
   logic [15:0] rdq[$];
   logic [1:0]  rdbeq[$];
   logic [15:0] ref_mem   [int];
   logic [15:0] model_mem [int];

   int vectors = 0;
   int errors  = 0;
   int ras_falls = 0;
   int last_open_run = -1;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int col_bits(input logic [2:0] code);
      return 8 + ((code > 3'd3) ? 3 : int'(code));
   endfunction

   function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] nw,
                                              input logic [1:0] be);
      return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
   endfunction

   // Driver: called at a negedge, returns at the negedge after acceptance.
   task automatic access(input logic [WADDR_W-1:0] w, input bit wr, input logic [1:0] be,
                         input logic [15:0] d);
      item_t it;
      logic [15:0] old;
      req_valid = 1'b1; req_waddr = w; req_write = wr; req_be = be; req_wdata = d;
      while (!req_ready) @(negedge clk);
      it.w = w; it.wr = wr; it.be = be; it.d = d;
      colq.push_back(it);
      old = ref_mem.exists(int'(w)) ? ref_mem[int'(w)] : 16'h0000;
      if (wr) ref_mem[int'(w)] = lane_merge(old, d, be);
      else begin
         rdq.push_back(old);
         rdbeq.push_back(be);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while ((colq.size() != 0 || rdq.size() != 0) && guard < 200) begin
         @(negedge clk); guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_closed();
      int guard = 0;
      while (!dram_ras_n && guard < 400) begin
         @(negedge clk); guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   // Monitor with behavioural memory model
   logic             p_ras = 1'b1, p_ucas = 1'b1, p_lcas = 1'b1;
   logic [PIN_W-1:0] p_addr = '0, row_lat = '0;
   int               high_run = 0, open_run = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         bit          cas_now;
         cas_now = !dram_ucas_n || !dram_lcas_n;
         if (p_ras && !dram_ras_n) begin
            ras_falls++;
            row_lat = dram_addr;
            chk(high_run >= 1, "R7", "precharge states before row open", high_run, 1);
         end
         if (dram_ras_n) high_run++; else high_run = 0;
         if (!dram_we_n && !dram_oe_n) chk(0, "R9", "we_n/oe_n both low", 0, 1);
         if (!p_ucas || !p_lcas) begin
            chk(dram_ucas_n && dram_lcas_n, "R3", "strobe longer than one state",
                {dram_ucas_n, dram_lcas_n}, 2'b11);
            if (!cfg_burst_en) chk(dram_ras_n, "R1", "row not closed after strobe", dram_ras_n, 1);
         end
         if (cas_now) begin
            item_t it;
            int s, key;
            logic [PIN_W-1:0] er, ec;
            logic [15:0] v;
            chk(!dram_ras_n, "R9", "column strobe with row closed", dram_ras_n, 0);
            chk(p_ucas && p_lcas && !p_ras && (p_addr == dram_addr), "R3",
                "column setup state", p_addr, dram_addr);
            if (colq.size() == 0) chk(0, "R2", "unexpected column cycle", 1, 0);
            else begin
               it = colq.pop_front();
               s  = col_bits(cfg_shift);
               er = PIN_W'(it.w >> s);
               ec = PIN_W'(it.w & ((WADDR_W'(1) << s) - WADDR_W'(1)));
               chk(row_lat == er, "R4", "row address", row_lat, er);
               chk(dram_addr == ec, "R4", "column address", dram_addr, ec);
               chk({!dram_ucas_n, !dram_lcas_n} == it.be, "R5", "lane strobes",
                   {!dram_ucas_n, !dram_lcas_n}, it.be);
               chk(dram_we_n == !it.wr && dram_oe_n == it.wr, "R6", "we_n/oe_n",
                   {dram_we_n, dram_oe_n}, {!it.wr, it.wr});
               key = (int'(row_lat) << s) | int'(dram_addr);
               v = model_mem.exists(key) ? model_mem[key] : 16'h0000;
               if (it.wr) begin
                  chk(dram_dq_oe && dram_dq_o == it.d, "R6", "write data on bus",
                      dram_dq_o, it.d);
                  model_mem[key] = lane_merge(v, dram_dq_o, {!dram_ucas_n, !dram_lcas_n});
               end else begin
                  dram_dq_i <= {!dram_ucas_n ? v[15:8] : 8'h00, !dram_lcas_n ? v[7:0] : 8'h00};
               end
            end
            open_run = 0;
         end else if (!dram_ras_n) begin
            open_run++;
         end
         if (!p_ras && dram_ras_n) last_open_run = open_run;
         if (rsp_valid) begin
            if (rdq.size() == 0) chk(0, "R6", "unexpected response", 1, 0);
            else begin
               logic [15:0] e, m;
               logic [1:0]  b;
               e = rdq.pop_front();
               b = rdbeq.pop_front();
               m = {{8{b[1]}}, {8{b[0]}}};
               chk((rsp_rdata & m) == (e & m), "R6", "read data", rsp_rdata & m, e & m);
            end
         end
         p_ras = dram_ras_n; p_ucas = dram_ucas_n; p_lcas = dram_lcas_n; p_addr = dram_addr;
      end
   end

   task automatic finish_sim();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         finish_sim();
      end
   end

   initial begin
      logic [WADDR_W-1:0] base;
      int r0;
      base = 23'h05A5C3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(dram_ras_n && dram_ucas_n && dram_lcas_n, "R10", "strobes after reset",
          {dram_ras_n, dram_ucas_n, dram_lcas_n}, 3'b111);
      chk(dram_we_n && dram_oe_n, "R10", "enables after reset", {dram_we_n, dram_oe_n}, 2'b11);
      chk(req_ready && !rsp_valid, "R10", "handshake after reset", {req_ready, rsp_valid}, 2'b10);

      // R1: plain mode, same row six times -> six row opens
      cfg_burst_en = 1'b0; cfg_shift = 3'd2;
      r0 = ras_falls;
      for (int i = 0; i < 3; i++) access(base + WADDR_W'(i), 1'b1, 2'b11, 16'hA000 + 16'(i));
      for (int i = 0; i < 3; i++) access(base + WADDR_W'(i), 1'b0, 2'b11, 16'h0);
      drain();
      chk(ras_falls - r0 == 6, "R1", "row opens in plain mode", ras_falls - r0, 6);
      wait_closed();

      // R2: page mode, eight accesses to one row -> one row open
      cfg_burst_en = 1'b1; cfg_idle_limit = 8'd4;
      r0 = ras_falls;
      for (int i = 0; i < 4; i++) access(base + WADDR_W'(8 + i), 1'b1, 2'b11, 16'h5100 + 16'(i));
      for (int i = 0; i < 4; i++) access(base + WADDR_W'(8 + i), 1'b0, 2'b11, 16'h0);
      drain();
      chk(ras_falls - r0 == 1, "R2", "row opens in page mode", ras_falls - r0, 1);
      wait_closed();
      // R8: idle close after limit+1 states
      chk(last_open_run == 5, "R8", "idle states before close (limit 4)", last_open_run, 5);

      cfg_idle_limit = 8'd0;
      access(base, 1'b0, 2'b11, 16'h0);
      drain();
      wait_closed();
      chk(last_open_run == 1, "R8", "idle states before close (limit 0)", last_open_run, 1);
      cfg_idle_limit = 8'd6;

      // R7: row miss in page mode
      r0 = ras_falls;
      access(base, 1'b1, 2'b11, 16'h1111);
      access(base + (WADDR_W'(1) << 10), 1'b1, 2'b11, 16'h2222);
      access(base, 1'b0, 2'b11, 16'h0);
      access(base + (WADDR_W'(1) << 10), 1'b0, 2'b11, 16'h0);
      drain();
      chk(ras_falls - r0 == 4, "R7", "row opens across misses", ras_falls - r0, 4);
      wait_closed();

      // R4: every column-width code, including a clamped one
      for (int code = 0; code < 5; code++) begin
         int s;
         logic [WADDR_W-1:0] a, b, c;
         cfg_shift = 3'(code);
         s = col_bits(3'(code));
         a = base; b = base ^ (WADDR_W'(1) << (s - 1)); c = base ^ (WADDR_W'(1) << s);
         r0 = ras_falls;
         access(a, 1'b1, 2'b11, 16'h3000 + 16'(code));
         access(b, 1'b1, 2'b11, 16'h4000 + 16'(code));
         access(c, 1'b1, 2'b11, 16'h6000 + 16'(code));
         access(a, 1'b0, 2'b11, 16'h0);
         access(b, 1'b0, 2'b11, 16'h0);
         access(c, 1'b0, 2'b11, 16'h0);
         drain();
         chk(ras_falls - r0 == 4, "R4", "row opens for column width", ras_falls - r0, 4);
         wait_closed();
      end

      // R5: byte lanes
      cfg_shift = 3'd2;
      access(base + 23'd40, 1'b1, 2'b11, 16'hFFFF);
      access(base + 23'd40, 1'b1, 2'b10, 16'h12EE);
      access(base + 23'd40, 1'b1, 2'b01, 16'hDD34);
      access(base + 23'd40, 1'b0, 2'b11, 16'h0);
      access(base + 23'd40, 1'b0, 2'b10, 16'h0);
      access(base + 23'd40, 1'b0, 2'b01, 16'h0);
      drain();
      wait_closed();
      chk(colq.size() == 0 && rdq.size() == 0, "R6", "all accesses completed",
          colq.size() + rdq.size(), 0);

      done = 1;
      finish_sim();
   end

endmodule